// File: doc/BRIEF.md
# GPIO Bank Controller with Masked Line Configuration

This block controls one bank of general-purpose I/O lines through a small synchronous register bus. Per-line settings are not written through one register per line. Software first loads a line-select mask and then writes one configuration word. That word is copied into every line whose mask bit is set. Each line's configuration holds a function code and a direction bit. Code zero means the line is plain GPIO. Codes one to seven hand the pad to one of seven alternate peripheral functions.

The output level of every GPIO line comes from an output latch. The latch is changed only through two registers. One sets the lines written with a one and the other clears them. A level register returns the synchronized pad inputs of all lines, whatever each line's direction. The bank width is a parameter. Line positions above the implemented count read as zero and ignore writes.

Read data is registered: the value for the address presented on one clock edge appears after that edge. Writes take effect on the edge where the write enable is high.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every register is zero: the mask reads 0, configuration read-back is 0, and every line is a GPIO input with pad_o, pad_oe and pad_fsel all low.
- R2: A write to address 0 loads the line-select mask from write data bit i for line i. Reading address 0 returns the mask.
- R3: A write to address 1 stores function code wdata[2:0] and direction wdata[7] (1 = output) into every line whose mask bit is set. Unselected lines keep their configuration, and an all-zero mask changes nothing.
- R4: Reading address 1 returns the configuration of the lowest-numbered selected line, as direction in bit 7 and function in bits 2:0, with other bits zero. The read returns 0 when the mask is all zero.
- R5: For line i, pad_oe[i] is high exactly when the line's direction is output and its function code is 0. pad_fsel[3*i+2:3*i] always carries the line's function code.
- R6: A write to address 2 drives high the output latch of every line written with a 1, and leaves the lines written with 0 unchanged. pad_o shows the latch.
- R7: A write to address 3 drives low the output latch of every line written with a 1, and leaves the lines written with 0 unchanged.
- R8: Reading address 4 returns pad_i after a two-flop synchronizer. A pad change made before a clock edge appears in read data three edges later, whatever the line's direction.
- R9: Bit positions at or above the implemented line count read as zero from the mask and level registers. Writes to those positions have no effect on any output.
- R10: Reads of addresses 2 and 3, and of every address above 4, return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Register word address |
| bus_we | input | 1 | Write enable for the addressed register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the previous cycle's address |
| pad_i | input | LINES | Pad input levels, asynchronous |
| pad_o | output | LINES | Output latch value per line |
| pad_oe | output | LINES | Pad output enable per line |
| pad_fsel | output | 3*LINES | Function code per line, three bits each |

## Verification
The hardest case to reach is a mask with several lines selected when those lines hold different configurations. Read-back must then pick the lowest line, and a later shared write must rewrite all of them at once. The stimulus builds this in steps. It configures overlapping subsets through successive masks, then widens the mask to cover lines that already differ. Configuration read-back and the pad enables are compared at every step. A second case that needs care is the level register's three-edge latency. The bench changes a pad between edges and samples read data after the second and after the third edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // function code width and position of the direction bit in the config word
  localparam int FUNC_W  = 3;
  localparam int DIR_POS = 7;

  localparam logic [FUNC_W-1:0] FUNC_GPIO = '0;

  typedef struct packed {
    logic              dir;   // 1 = output
    logic [FUNC_W-1:0] func;  // 0 = GPIO, 1..7 = alternates
  } line_cfg_t;

  localparam int CFG_W = $bits(line_cfg_t);

  typedef enum logic [2:0] {
    REG_SEL = 3'd0,
    REG_CFG = 3'd1,
    REG_SET = 3'd2,
    REG_CLR = 3'd3,
    REG_LVL = 3'd4
  } reg_addr_e;

  function automatic logic [DIR_POS:0] cfg_pack(input line_cfg_t c);
    logic [DIR_POS:0] w;
    w               = '0;
    w[DIR_POS]      = c.dir;
    w[FUNC_W-1:0]   = c.func;
    return w;
  endfunction

endpackage

// File: rtl/gpio_regif.sv
module gpio_regif
  import gpio_bank_pkg::*;
#(
  parameter int LINES  = 20,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  line_cfg_t         sel_cfg,
  input  logic [LINES-1:0]  lvl,
  output logic [LINES-1:0]  mask,
  output logic              cfg_we,
  output line_cfg_t         cfg_wr,
  output logic [LINES-1:0]  set_v,
  output logic [LINES-1:0]  clr_v
);

  localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(REG_SEL);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(REG_CFG);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(REG_SET);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(REG_CLR);
  localparam logic [ADDR_W-1:0] A_LVL = ADDR_W'(REG_LVL);

  logic [LINES-1:0]  mask_q, mask_nxt;
  logic              mask_en;
  logic [DATA_W-1:0] rd_q, rd_nxt;

  // write strobes
  always_comb begin
    mask_en  = bus_we && (bus_addr == A_SEL);
    mask_nxt = bus_wdata[LINES-1:0];
    cfg_we   = bus_we && (bus_addr == A_CFG);
    cfg_wr   = '{dir: bus_wdata[DIR_POS], func: bus_wdata[FUNC_W-1:0]};
    set_v    = (bus_we && (bus_addr == A_SET)) ? bus_wdata[LINES-1:0] : '0;
    clr_v    = (bus_we && (bus_addr == A_CLR)) ? bus_wdata[LINES-1:0] : '0;
  end

  // read mux
  always_comb begin
    case (bus_addr)
      A_SEL:   rd_nxt = DATA_W'(mask_q);
      A_CFG:   rd_nxt = DATA_W'(cfg_pack(sel_cfg));
      A_LVL:   rd_nxt = DATA_W'(lvl);
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_nxt;
    end
  end

  assign mask      = mask_q;
  assign bus_rdata = rd_q;

  // write-data bits outside any field are intentionally ignored
  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

endmodule

// File: rtl/gpio_line_cfg.sv
module gpio_line_cfg
  import gpio_bank_pkg::*;
#(
  parameter int LINES = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LINES-1:0]      mask,
  input  logic                  cfg_we,
  input  line_cfg_t             cfg_wr,
  output line_cfg_t [LINES-1:0] cfg_q,
  output line_cfg_t             sel_cfg
);

  line_cfg_t [LINES-1:0] cfg_r;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic      en;
    line_cfg_t nxt;

    always_comb begin
      en  = cfg_we && mask[i];
      nxt = cfg_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_r[i] <= '0;
      end else if (en) begin
        cfg_r[i] <= nxt;
      end
    end
  end

  // lowest selected line wins the read-back
  always_comb begin
    sel_cfg = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (mask[i]) sel_cfg = cfg_r[i];
    end
  end

  assign cfg_q = cfg_r;

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int LINES = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] set_v,
  input  logic [LINES-1:0] clr_v,
  output logic [LINES-1:0] q
);

  logic [LINES-1:0] q_r, q_nxt;
  logic             en;

  always_comb begin
    en    = |(set_v | clr_v);
    q_nxt = (q_r | set_v) & ~clr_v;  // clear wins over set
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (en) begin
      q_r <= q_nxt;
    end
  end

  assign q = q_r;

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int LINES  = 20,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pad_i,
  output logic [LINES-1:0] lvl
);

  logic [STAGES-1:0][LINES-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= pad_i;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign lvl = stg[STAGES-1];

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int LINES  = 20,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [LINES-1:0]   pad_i,
  output logic [LINES-1:0]   pad_o,
  output logic [LINES-1:0]   pad_oe,
  output logic [3*LINES-1:0] pad_fsel
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  logic [LINES-1:0]      mask;
  logic                  cfg_we;
  line_cfg_t             cfg_wr;
  line_cfg_t             sel_cfg;
  line_cfg_t [LINES-1:0] cfg_q;
  logic [LINES-1:0]      set_v, clr_v;
  logic [LINES-1:0]      lvl;

  gpio_regif #(.LINES(LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regif (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .sel_cfg   (sel_cfg),
    .lvl       (lvl),
    .mask      (mask),
    .cfg_we    (cfg_we),
    .cfg_wr    (cfg_wr),
    .set_v     (set_v),
    .clr_v     (clr_v)
  );

  gpio_line_cfg #(.LINES(LINES)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .mask    (mask),
    .cfg_we  (cfg_we),
    .cfg_wr  (cfg_wr),
    .cfg_q   (cfg_q),
    .sel_cfg (sel_cfg)
  );

  gpio_out_latch #(.LINES(LINES)) u_latch (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_v (set_v),
    .clr_v (clr_v),
    .q     (pad_o)
  );

  gpio_in_sync #(.LINES(LINES), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .pad_i (pad_i),
    .lvl   (lvl)
  );

  // pad steering: output enable only for GPIO lines set as outputs
  for (genvar i = 0; i < LINES; i++) begin : g_pad
    assign pad_oe[i]           = cfg_q[i].dir && (cfg_q[i].func == FUNC_GPIO);
    assign pad_fsel[3*i +: 3]  = cfg_q[i].func;
  end

endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
  import gpio_bank_pkg::*;
#(
  parameter int LINES  = 20,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_we,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [LINES-1:0]   pad_o,
  input logic [LINES-1:0]   pad_oe,
  input logic [3*LINES-1:0] pad_fsel
);

  localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(REG_SEL);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(REG_CFG);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(REG_SET);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(REG_CLR);
  localparam logic [ADDR_W-1:0] A_LVL = ADDR_W'(REG_LVL);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  logic [LINES-1:0] gpio_lines;
  for (genvar i = 0; i < LINES; i++) begin : g_fn
    assign gpio_lines[i] = (pad_fsel[3*i +: 3] == FUNC_GPIO);
  end

  // R5
  oe_gpio_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~gpio_lines) == '0);

  // R6
  set_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_SET) |=>
      ((pad_o & $past(bus_wdata[LINES-1:0])) == $past(bus_wdata[LINES-1:0])));

  // R7
  clr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CLR) |=> ((pad_o & $past(bus_wdata[LINES-1:0])) == '0));

  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && (bus_addr == A_SET || bus_addr == A_CLR)) |=> $stable(pad_o));

  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == A_CFG) |=> ($stable(pad_fsel) && $stable(pad_oe)));

  // R10
  unused_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ($past(bus_addr) == A_SET || $past(bus_addr) == A_CLR ||
                 $past(bus_addr) > A_LVL)) |-> (bus_rdata == '0));

  if (LINES < DATA_W) begin : g_upper
    // R9
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && ($past(bus_addr) == A_SEL || $past(bus_addr) == A_LVL)) |->
        (bus_rdata[DATA_W-1:LINES] == '0));
  end

  logic unused_chk;
  assign unused_chk = ^bus_wdata;

endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
  .LINES(LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_o     (pad_o),
  .pad_oe    (pad_oe),
  .pad_fsel  (pad_fsel)
);

// File: tb/gpio_bank_ctrl_bench.sv
module gpio_bank_ctrl_bench;

  localparam int LINES  = 20;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  localparam logic [1:0] OP_WR = 2'd0;  // bus write
  localparam logic [1:0] OP_RD = 2'd1;  // bus read, compare read data
  localparam logic [1:0] OP_OE = 2'd2;  // compare pad_oe
  localparam logic [1:0] OP_PO = 2'd3;  // compare pad_o

  // entry: {op, requirement number, addr, write data, expected}
  localparam int NV = 38;
  localparam logic [72:0] VEC [NV] = '{
    {OP_WR, 4'd2,  3'd0, 32'h0000_0005, 32'h0},           // R2 select lines 0,2
    {OP_RD, 4'd2,  3'd0, 32'h0,         32'h0000_0005},   // R2
    {OP_WR, 4'd3,  3'd1, 32'h0000_0080, 32'h0},           // R3 gpio output
    {OP_RD, 4'd4,  3'd1, 32'h0,         32'h0000_0080},   // R4
    {OP_OE, 4'd5,  3'd0, 32'h0,         32'h0000_0005},   // R5
    {OP_WR, 4'd6,  3'd2, 32'h0000_0007, 32'h0},           // R6
    {OP_PO, 4'd6,  3'd0, 32'h0,         32'h0000_0007},   // R6
    {OP_WR, 4'd7,  3'd3, 32'h0000_0002, 32'h0},           // R7
    {OP_PO, 4'd7,  3'd0, 32'h0,         32'h0000_0005},   // R7
    {OP_WR, 4'd2,  3'd0, 32'h0000_0006, 32'h0},           // R2 lines 1,2
    {OP_WR, 4'd3,  3'd1, 32'h0000_0083, 32'h0},           // R3 alt 3, dir out
    {OP_OE, 4'd5,  3'd0, 32'h0,         32'h0000_0001},   // R5 alt lines not enabled
    {OP_RD, 4'd4,  3'd1, 32'h0,         32'h0000_0083},   // R4 lowest is line 1
    {OP_WR, 4'd2,  3'd0, 32'h0000_0001, 32'h0},
    {OP_RD, 4'd3,  3'd1, 32'h0,         32'h0000_0080},   // R3 line 0 untouched
    {OP_WR, 4'd2,  3'd0, 32'h0000_0008, 32'h0},
    {OP_WR, 4'd3,  3'd1, 32'h0000_0005, 32'h0},           // R3 alt 5 input
    {OP_RD, 4'd3,  3'd1, 32'h0,         32'h0000_0005},   // R3
    {OP_OE, 4'd5,  3'd0, 32'h0,         32'h0000_0001},   // R5
    {OP_WR, 4'd9,  3'd0, 32'hFFFF_FFFF, 32'h0},           // R9
    {OP_RD, 4'd9,  3'd0, 32'h0,         32'h000F_FFFF},   // R9 upper mask bits zero
    {OP_RD, 4'd4,  3'd1, 32'h0,         32'h0000_0080},   // R4 lowest of mixed set
    {OP_WR, 4'd3,  3'd1, 32'h0000_0080, 32'h0},           // R3 all lines
    {OP_OE, 4'd3,  3'd0, 32'h0,         32'h000F_FFFF},   // R3
    {OP_WR, 4'd6,  3'd2, 32'hFFFF_FFFF, 32'h0},           // R6
    {OP_PO, 4'd6,  3'd0, 32'h0,         32'h000F_FFFF},   // R6
    {OP_WR, 4'd9,  3'd3, 32'hFFF0_0000, 32'h0},           // R9 clear beyond lines
    {OP_PO, 4'd9,  3'd0, 32'h0,         32'h000F_FFFF},   // R9 no effect
    {OP_WR, 4'd4,  3'd0, 32'h0000_0000, 32'h0},
    {OP_RD, 4'd4,  3'd1, 32'h0,         32'h0000_0000},   // R4 empty mask
    {OP_WR, 4'd3,  3'd1, 32'h0000_0007, 32'h0},           // R3 empty mask write
    {OP_OE, 4'd3,  3'd0, 32'h0,         32'h000F_FFFF},   // R3 nothing changed
    {OP_RD, 4'd10, 3'd5, 32'h0,         32'h0000_0000},   // R10
    {OP_RD, 4'd10, 3'd2, 32'h0,         32'h0000_0000},   // R10
    {OP_WR, 4'd7,  3'd3, 32'h0000_000F, 32'h0},           // R7
    {OP_PO, 4'd7,  3'd0, 32'h0,         32'h000F_FFF0},   // R7
    {OP_WR, 4'd6,  3'd2, 32'h0000_0000, 32'h0},           // R6 zeros hold
    {OP_PO, 4'd6,  3'd0, 32'h0,         32'h000F_FFF0}    // R6
  };

  logic               clk;
  logic               rst_n;
  logic [ADDR_W-1:0]  bus_addr;
  logic               bus_we;
  logic [DATA_W-1:0]  bus_wdata;
  logic [DATA_W-1:0]  bus_rdata;
  logic [LINES-1:0]   pad_i;
  logic [LINES-1:0]   pad_o;
  logic [LINES-1:0]   pad_oe;
  logic [3*LINES-1:0] pad_fsel;

  int  n_chk;
  int  n_bad;
  bit  done;

  gpio_bank_ctrl #(.LINES(LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_gpio_bank_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_i     (pad_i),
    .pad_o     (pad_o),
    .pad_oe    (pad_oe),
    .pad_fsel  (pad_fsel)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    bus_addr = a;
    bus_we   = 1'b0;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin
    logic [1:0]  vop;
    logic [3:0]  vreq;
    logic [2:0]  vaddr;
    logic [31:0] vwd, vexp, rd;
    string       tag;

    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pad_i = '0;
    repeat (3) @(negedge clk);

    // reset state, checked while reset is held
    check(32'(pad_o),    32'h0, "R1 pad_o");
    check(32'(pad_oe),   32'h0, "R1 pad_oe");
    check(32'(pad_fsel), 32'h0, "R1 pad_fsel");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_read(3'd0, rd); check(rd, 32'h0, "R1 mask");
    bus_read(3'd1, rd); check(rd, 32'h0, "R1 cfg");

    // table walk
    for (int i = 0; i < NV; i++) begin
      {vop, vreq, vaddr, vwd, vexp} = VEC[i];
      tag = $sformatf("R%0d vector %0d", vreq, i);
      case (vop)
        OP_WR: bus_write(vaddr, vwd);
        OP_RD: begin bus_read(vaddr, rd); check(rd, vexp, tag); end
        OP_OE: check(32'(pad_oe), vexp, tag);
        default: check(32'(pad_o), vexp, tag);
      endcase
    end

    // R8 level register latency, all lines currently outputs
    bus_addr = 3'd4;
    pad_i    = 20'hABCDE;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(bus_rdata, 32'h0, "R8 after two edges");
    @(posedge clk); @(negedge clk);
    check(bus_rdata, 32'h000A_BCDE, "R8 after three edges");
    pad_i = 20'h12345;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(bus_rdata, 32'h0001_2345, "R8 second pattern");

    // R5 alternate function on line 4: code visible, enable low
    bus_write(3'd0, 32'h0000_0010);
    bus_write(3'd1, 32'h0000_0087);
    check(32'(pad_fsel[12 +: 3]), 32'h7, "R5 fsel line 4");
    check(32'(pad_oe[4]),         32'h0, "R5 oe line 4");
    check(32'(pad_fsel[9 +: 3]),  32'h0, "R5 fsel line 3 kept");

    // R1 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check(32'(pad_o),    32'h0, "R1 pad_o after reset");
    check(32'(pad_oe),   32'h0, "R1 pad_oe after reset");
    check(32'(pad_fsel), 32'h0, "R1 pad_fsel after reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(3'd0, rd); check(rd, 32'h0, "R1 mask after reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule